// File: doc/BRIEF.md
# Descriptor Table DMA Sequencer

This block runs up to four independent channels ("threads") of DMA work. Each thread owns a ring of fixed-size descriptors in memory, bounded by a start and an end address. Software writes those bounds, pulses a per-thread initialise bit so that the sequencer takes them over and rewinds its pointer, enables the thread, and then posts how many new descriptors it has placed in the ring.

The sequencer picks an eligible thread, reads its next 32-byte descriptor one word at a time over a single-outstanding memory read port, and decodes it. It then presents a transfer to an external data mover: source, destination, length, pre-transfer byte order code, inline-processing type and the inline-processing control word. When the mover signals completion, the thread's pending count drops by one and its pointer moves to the next slot, wrapping at the end address. A descriptor can ask for an interrupt, which sets a sticky per-thread status bit.

Top module: `dsq_top`

## Requirements
- R1: After reset every pending count reads 0, the interrupt status reads 0, `irq` is low, and neither `mem_req` nor `mv_req` is asserted.
- R2: Registers are selected by the word index `reg_addr`: 0 holds the global enable at bit 0; 1 holds the thread enables at bits 8+n and the initialise strobes at bits 24+n; 2 is the post/pending register; 3 is the interrupt status; 4+n and 8+n hold the start and end byte addresses of thread n. `reg_rdata` shows the addressed register one clock after `reg_addr` is applied.
- R3: A descriptor is 8 words read from the thread pointer at byte addresses pointer+4k, k rising from 0 to 7, one read in flight at a time. Word 0 is control (bit 21 asks for an interrupt, bits 24:22 the inline type, bits 29:27 the pre-transfer endian code), word 1 the source, word 2 the destination, word 3 the length, word 6 the inline control word; words 4, 5 and 7 are not used.
- R4: `mv_req` stays high with steady fields until `mv_done`; each completion lowers that thread's pending count by one.
- R5: Writing register 2 with the thread number in bits 15:8 and a count in bits 7:0 adds the count to that thread's pending counter; reading register 2 returns thread n's count in bits [8n+7:8n].
- R6: After a descriptor completes the pointer advances by 32 bytes; if the result is at or above the end address it becomes the start address.
- R7: Writing 1 to bit 24+n of register 1 copies thread n's start and end registers into the working bounds and sets its pointer to start; those bits always read back as 0.
- R8: Threads that are enabled with a nonzero pending count are served in round-robin order, starting after the thread served last (thread 0 first after reset), one complete descriptor per turn.
- R9: With the global enable clear, or the thread enable clear, no descriptor of that thread is fetched and its pending count stays unchanged.
- R10: Clearing a thread's enable while its descriptor is in flight lets that descriptor finish and be counted; the remaining pending count is kept and served once the thread is enabled again.
- R11: A completed descriptor with control bit 21 set sets status bit n of register 3; writing 1 to a status bit clears it; `irq` is high while any status bit is set, one clock behind the status.
- R12: Only bits 24:0 of word 3 form the transfer length; the upper bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |
| mem_req | output | 1 | One-cycle descriptor word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Transfer request to the mover, held until done |
| mv_src | output | 32 | Source address |
| mv_dst | output | 32 | Destination address |
| mv_len | output | 25 | Transfer length in bytes |
| mv_pre_endian | output | 3 | Pre-transfer byte order code |
| mv_inline | output | 3 | Inline processing type |
| mv_inline_ctl | output | 32 | Inline processing control word |
| mv_done | input | 1 | Mover completion pulse |
| irq | output | 1 | Interrupt, OR of the status bits |

## Verification
A wrong pointer, a wrong working bound or a miscounted pending value shows up at the mover port as soon as the affected thread next gets a turn: the presented source, destination, length and codes no longer match the descriptor the ring position predicts, or a transfer appears when none is due. Arbitration faults appear as a different thread's descriptor on the very next request. Counter faults also appear in the pending read-back one clock after a completion, and a lost or stuck interrupt bit appears on `irq` two clocks after the completion or the clearing write.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int DESC_WORDS = 8;
  localparam int DESC_BYTES = DESC_WORDS * 4;
  localparam int LEN_W      = 25;

  // register word indices
  localparam logic [3:0] RA_CTL  = 4'd0;
  localparam logic [3:0] RA_THR  = 4'd1;
  localparam logic [3:0] RA_POST = 4'd2;
  localparam logic [3:0] RA_IRQ  = 4'd3;

  // control word field positions
  localparam int CB_IRQ = 21;
  localparam int CB_INL = 22;
  localparam int CB_PRE = 27;

  // thread register bit groups
  localparam int TB_EN   = 8;
  localparam int TB_INIT = 24;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_MOVE, S_FIN} eng_state_t;
endpackage

// File: rtl/dsq_rr.sv
module dsq_rr #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] req,
  input  logic          take,
  output logic          gnt_vld,
  output logic [TW-1:0] gnt_idx
);
  logic [TW-1:0] last_q;

  // search starts one past the last served thread
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = last_q;
    for (int i = 1; i <= NT; i++) begin
      if (!gnt_vld && req[(int'(last_q) + i) % NT]) begin
        gnt_vld = 1'b1;
        gnt_idx = TW'((int'(last_q) + i) % NT);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last_q <= TW'(NT - 1);
    else if (take) last_q <= gnt_idx;
  end
endmodule

// File: rtl/dsq_fetch.sv
module dsq_fetch #(
  parameter int AW = 16,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gnt_vld,
  input  logic [TW-1:0] gnt_idx,
  input  logic [AW-1:0] base_addr,
  output logic          take,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          mv_req,
  output logic [31:0]   mv_src,
  output logic [31:0]   mv_dst,
  output logic [24:0]   mv_len,
  output logic [2:0]    mv_pre_endian,
  output logic [2:0]    mv_inline,
  output logic [31:0]   mv_inline_ctl,
  input  logic          mv_done,
  output logic          fin,
  output logic [TW-1:0] fin_thread,
  output logic          fin_irq
);
  import dsq_pkg::*;

  eng_state_t st_q;
  logic [2:0] widx_q;

  assign take = (st_q == S_IDLE) && gnt_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= S_IDLE;
      widx_q        <= '0;
      mem_req       <= 1'b0;
      mem_addr      <= '0;
      mv_req        <= 1'b0;
      mv_src        <= '0;
      mv_dst        <= '0;
      mv_len        <= '0;
      mv_pre_endian <= '0;
      mv_inline     <= '0;
      mv_inline_ctl <= '0;
      fin           <= 1'b0;
      fin_thread    <= '0;
      fin_irq       <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      fin     <= 1'b0;
      case (st_q)
        S_IDLE: if (gnt_vld) begin
          fin_thread <= gnt_idx;
          mem_addr   <= base_addr;
          mem_req    <= 1'b1;
          widx_q     <= '0;
          st_q       <= S_WAIT;
        end
        S_WAIT: if (mem_rvalid) begin
          case (widx_q)
            3'd0: begin
              fin_irq       <= mem_rdata[CB_IRQ];
              mv_inline     <= mem_rdata[CB_INL +: 3];
              mv_pre_endian <= mem_rdata[CB_PRE +: 3];
            end
            3'd1:    mv_src        <= mem_rdata;
            3'd2:    mv_dst        <= mem_rdata;
            3'd3:    mv_len        <= mem_rdata[LEN_W-1:0];
            3'd6:    mv_inline_ctl <= mem_rdata;
            default: ;
          endcase
          if (widx_q == 3'(DESC_WORDS - 1)) begin
            mv_req <= 1'b1;
            st_q   <= S_MOVE;
          end else begin
            widx_q   <= widx_q + 3'd1;
            mem_addr <= mem_addr + AW'(4);
            mem_req  <= 1'b1;
          end
        end
        S_MOVE: if (mv_done) begin
          mv_req <= 1'b0;
          fin    <= 1'b1;
          st_q   <= S_FIN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsq_top.sv
module dsq_top #(
  parameter int NT    = 4,
  parameter int AW    = 16,
  parameter int CNT_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          mv_req,
  output logic [31:0]   mv_src,
  output logic [31:0]   mv_dst,
  output logic [24:0]   mv_len,
  output logic [2:0]    mv_pre_endian,
  output logic [2:0]    mv_inline,
  output logic [31:0]   mv_inline_ctl,
  input  logic          mv_done,
  output logic          irq
);
  import dsq_pkg::*;

  localparam int TW = (NT > 1) ? $clog2(NT) : 1;

  logic                 glob_q;
  logic [NT-1:0]        en_q, irq_st_q, req;
  logic [AW-1:0]        st_sh[NT], end_sh[NT], st_a[NT], end_a[NT], ptr_q[NT];
  logic [AW-1:0]        ptr_nx[NT];
  logic [CNT_W-1:0]     pend_q[NT], pend_d[NT];
  logic                 gnt_vld, take, fin, fin_irq;
  logic [TW-1:0]        gnt_idx, fin_thread;
  logic [31:0]          rd_d;
  logic                 wr_thr, wr_post, wr_irq;
  logic                 unused_wdata;

  assign wr_thr       = reg_wr && reg_addr == RA_THR;
  assign wr_post      = reg_wr && reg_addr == RA_POST;
  assign wr_irq       = reg_wr && reg_addr == RA_IRQ;
  assign unused_wdata = ^{reg_wdata[31:28], reg_wdata[23:16]};

  generate
    for (genvar n = 0; n < NT; n++) begin : g_thr
      logic [AW-1:0]    step;
      logic [CNT_W-1:0] add;
      logic             dec;
      assign req[n]    = glob_q && en_q[n] && (pend_q[n] != '0);
      assign step      = ptr_q[n] + AW'(DESC_BYTES);
      assign ptr_nx[n] = (step >= end_a[n]) ? st_a[n] : step;
      assign add       = (wr_post && reg_wdata[15:8] == 8'(n)) ? reg_wdata[CNT_W-1:0] : '0;
      assign dec       = fin && fin_thread == TW'(n);
      assign pend_d[n] = pend_q[n] + add - CNT_W'(dec);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_q   <= 1'b0;
      en_q     <= '0;
      irq_st_q <= '0;
      irq      <= 1'b0;
      for (int n = 0; n < NT; n++) begin
        st_sh[n] <= '0; end_sh[n] <= '0; st_a[n] <= '0;
        end_a[n] <= '0; ptr_q[n]  <= '0; pend_q[n] <= '0;
      end
    end else begin
      if (reg_wr && reg_addr == RA_CTL) glob_q <= reg_wdata[0];
      if (wr_thr) en_q <= reg_wdata[TB_EN +: NT];
      for (int n = 0; n < NT; n++) begin
        if (reg_wr && reg_addr[3:2] == 2'b01 && reg_addr[1:0] == 2'(n)) st_sh[n]  <= reg_wdata[AW-1:0];
        if (reg_wr && reg_addr[3:2] == 2'b10 && reg_addr[1:0] == 2'(n)) end_sh[n] <= reg_wdata[AW-1:0];
        if (wr_thr && reg_wdata[TB_INIT + n]) begin
          st_a[n]  <= st_sh[n];
          end_a[n] <= end_sh[n];
          ptr_q[n] <= st_sh[n];
        end else if (fin && fin_thread == TW'(n)) begin
          ptr_q[n] <= ptr_nx[n];
        end
        pend_q[n] <= pend_d[n];
        if (fin && fin_irq && fin_thread == TW'(n)) irq_st_q[n] <= 1'b1;
        else if (wr_irq && reg_wdata[n])            irq_st_q[n] <= 1'b0;
      end
      irq <= |irq_st_q;
    end
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      RA_CTL:  rd_d[0] = glob_q;
      RA_THR:  rd_d[TB_EN +: NT] = en_q;
      RA_POST: for (int n = 0; n < NT; n++) rd_d[n*8 +: 8] = 8'(pend_q[n]);
      RA_IRQ:  rd_d[NT-1:0] = irq_st_q;
      default: begin
        if (reg_addr[3:2] == 2'b01)      rd_d[AW-1:0] = st_sh[TW'(reg_addr[1:0])];
        else if (reg_addr[3:2] == 2'b10) rd_d[AW-1:0] = end_sh[TW'(reg_addr[1:0])];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end

  dsq_rr #(.NT(NT), .TW(TW)) u_rr (
    .clk(clk), .rst(rst), .req(req), .take(take),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  dsq_fetch #(.AW(AW), .TW(TW)) u_fetch (
    .clk(clk), .rst(rst), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx),
    .base_addr(ptr_q[gnt_idx]), .take(take),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
    .mv_pre_endian(mv_pre_endian), .mv_inline(mv_inline), .mv_inline_ctl(mv_inline_ctl),
    .mv_done(mv_done), .fin(fin), .fin_thread(fin_thread), .fin_irq(fin_irq)
  );
endmodule

// File: rtl/dsq_chk.sv
module dsq_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic        mv_req,
  input logic        mv_done,
  input logic [31:0] mv_src,
  input logic [24:0] mv_len,
  input logic        irq
);
  // R4
  mv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mv_req && !mv_done |=> mv_req);

  // R4
  mv_steady_chk: assert property (@(posedge clk) disable iff (rst)
    mv_req && $past(mv_req) |-> $stable(mv_src) && $stable(mv_len));

  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R3
  fetch_move_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && mv_req));

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(reg_wr, 2));

  logic unused_rv;
  assign unused_rv = mem_rvalid;
endmodule

bind dsq_top dsq_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .mv_req(mv_req), .mv_done(mv_done), .mv_src(mv_src), .mv_len(mv_len), .irq(irq)
);

// File: tb/sim_dsq_top.sv
`timescale 1ns/1ps
module sim_dsq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mv_req;
  logic [31:0] mv_src, mv_dst, mv_inline_ctl;
  logic [24:0] mv_len;
  logic [2:0]  mv_pre_endian, mv_inline;
  logic        mv_done = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  dsq_top u0 (.*);

  logic [31:0] mem [0:1023];
  int n_chk = 0, n_bad = 0, mem_seen = 0;
  bit finished = 0;
  int exp_ptr[4], exp_st[4], exp_end[4], pend[4];
  int last = 3;
  logic [3:0] en_m = '0, exp_irq = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one read at a time, latency 1..3
  initial begin
    @(negedge clk);
    forever begin
      if (mem_req === 1'b1) begin
        automatic int a = int'(mem_addr);
        mem_seen++;
        repeat (1 + $urandom % 3) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem[a >> 2];
        @(negedge clk);
        mem_rvalid = 1'b0;
      end else @(negedge clk);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic set_table(input int t, input int slots);
    exp_st[t] = t * 32'h200; exp_end[t] = exp_st[t] + slots * 32; exp_ptr[t] = exp_st[t];
    wr(4'(4 + t), 32'(exp_st[t]));
    wr(4'(8 + t), 32'(exp_end[t]));
    wr(4'd1, (32'(en_m) << 8) | (32'h1 << (24 + t)));
  endtask

  task automatic post(input int t, input int c);
    pend[t] += c;
    wr(4'd2, 32'((t << 8) | c));
  endtask

  function automatic int next_thread();
    for (int i = 1; i <= 4; i++) begin
      int c = (last + i) % 4;
      if (en_m[c] && pend[c] > 0) return c;
    end
    return -1;
  endfunction

  task automatic wait_req(output int et);
    int tmo = 0;
    while (mv_req !== 1'b1 && tmo < 3000) begin @(negedge clk); tmo++; end
    et = next_thread();
    if (mv_req !== 1'b1 || et < 0) begin
      chk(0, "R8 expected mover request", 32'(mv_req), 32'(et));
      et = -1;
    end else begin
      automatic int b = exp_ptr[et] >> 2;
      chk(mv_src == mem[b+1] && mv_dst == mem[b+2], "R3 R6 R8 addresses", mv_src, mem[b+1]);
      chk(mv_len == mem[b+3][24:0], "R12 length", 32'(mv_len), 32'(mem[b+3][24:0]));
      chk({mv_pre_endian, mv_inline} == {mem[b][29:27], mem[b][24:22]}, "R3 codes",
          32'({mv_pre_endian, mv_inline}), 32'({mem[b][29:27], mem[b][24:22]}));
      chk(mv_inline_ctl == mem[b+6], "R3 inline word", mv_inline_ctl, mem[b+6]);
    end
  endtask

  task automatic finish_req(input int et);
    repeat ($urandom % 3) @(negedge clk);
    mv_done = 1'b1;
    @(negedge clk);
    mv_done = 1'b0;
    if (et >= 0) begin
      automatic int nx = exp_ptr[et] + 32;
      if (mem[exp_ptr[et] >> 2][21]) exp_irq[et] = 1'b1;
      exp_ptr[et] = (nx >= exp_end[et]) ? exp_st[et] : nx;
      pend[et]--;
      last = et;
    end
  endtask

  task automatic serve_one(output int et);
    wait_req(et);
    finish_req(et);
  endtask

  function automatic logic [31:0] lanes();
    logic [31:0] v = '0;
    for (int t = 0; t < 4; t++) v[t*8 +: 8] = 8'(pend[t]);
    return v;
  endfunction

  initial begin
    logic [31:0] d;
    int et, seen;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    for (int t = 0; t < 4; t++) pend[t] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'd2, d); chk(d == 0, "R1 pending after reset", d, 0);
    rd(4'd3, d); chk(d == 0, "R1 status after reset", d, 0);
    chk({irq, mv_req, mem_req} == 3'b000, "R1 outputs idle", 32'({irq, mv_req, mem_req}), 0);

    // R7 R2 init strobe reads back as zero, enable stays
    en_m = 4'b0001;
    set_table(0, 2);
    rd(4'd1, d); chk(d == 32'h100, "R7 R2 thread register readback", d, 32'h100);
    rd(4'd4, d); chk(d == 32'h0, "R2 start readback", d, 0);
    rd(4'd8, d); chk(d == 32'h40, "R2 end readback", d, 32'h40);

    // R9 global enable gates, R5 posting
    post(0, 3);
    seen = mem_seen;
    repeat (30) @(negedge clk);
    chk(mem_seen == seen && !mv_req, "R9 global gate", 32'(mem_seen), 32'(seen));
    rd(4'd2, d); chk(d == lanes(), "R5 pending lanes", d, lanes());
    wr(4'd0, 1);
    for (int i = 0; i < 3; i++) serve_one(et);  // third wraps to slot 0 (R6)
    repeat (4) @(negedge clk);
    rd(4'd2, d); chk(d == 0, "R4 pending drained", d, 0);

    // R7 init rewinds pointer mid-ring
    post(0, 1); serve_one(et);
    set_table(0, 2);
    post(0, 1); serve_one(et);

    // R10 disable while in flight
    post(0, 2);
    wait_req(et);
    en_m = 4'b0000; wr(4'd1, 32'h0);
    finish_req(et);
    repeat (30) @(negedge clk);
    chk(!mv_req, "R10 no further transfer", 32'(mv_req), 0);
    rd(4'd2, d); chk(d == 32'h1, "R10 pending kept", d, 32'h1);
    en_m = 4'b0001; wr(4'd1, 32'h100);
    serve_one(et);

    // R12 explicit length mask, R9 thread enable gate
    mem[(32'h200 >> 2) + 3] = 32'hFFFF_FFFF;
    set_table(1, 1);
    post(1, 1);
    repeat (30) @(negedge clk);
    chk(!mv_req, "R9 thread disabled", 32'(mv_req), 0);
    en_m = 4'b0011; wr(4'd1, 32'h300);
    wait_req(et);
    chk(mv_len == 25'h1FF_FFFF, "R12 upper bits dropped", 32'(mv_len), 32'h1FF_FFFF);
    finish_req(et);
    repeat (4) @(negedge clk);
    rd(4'd3, d); chk(d == 32'(exp_irq), "R11 status", d, 32'(exp_irq));
    wr(4'd3, 32'hF); exp_irq = '0;

    // random rounds, R8 order across all threads
    for (int r = 0; r < 8; r++) begin
      wr(4'd0, 0);
      en_m = 4'b1111;
      for (int t = 0; t < 4; t++) set_table(t, 1 + $urandom % 6);
      for (int t = 0; t < 4; t++) post(t, $urandom % 6);
      rd(4'd2, d); chk(d == lanes(), "R5 posted lanes", d, lanes());
      wr(4'd0, 1);
      et = 0;
      while ((pend[0] + pend[1] + pend[2] + pend[3]) > 0 && et >= 0) serve_one(et);
      repeat (4) @(negedge clk);
      rd(4'd2, d); chk(d == 0, "R4 all completed", d, 0);
      rd(4'd3, d); chk(d == 32'(exp_irq), "R11 sticky status", d, 32'(exp_irq));
      chk(irq == (exp_irq != 0), "R11 irq output", 32'(irq), 32'(exp_irq != 0));
      if (exp_irq != 0) begin
        automatic logic [3:0] low = exp_irq & (~exp_irq + 4'd1);
        wr(4'd3, 32'(low)); exp_irq &= ~low;
        rd(4'd3, d); chk(d == 32'(exp_irq), "R11 write-one clear", d, 32'(exp_irq));
        @(negedge clk);
        chk(irq == (exp_irq != 0), "R11 irq after clear", 32'(irq), 32'(exp_irq != 0));
        wr(4'd3, 32'hF); exp_irq = '0;
      end
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule